// File: doc/BRIEF.md
# Multi-cycle RISC datapath

This block is the data side of a small 32-bit processor. Each instruction runs over several short clock steps instead of one long one. Between the steps the work sits in holding registers: an instruction register, two operand registers, an ALU result register and a memory read register. The block also has a 32-entry register file, an ALU, sign and zero extension of the 16-bit immediate, and the program counter. It serves five instruction classes: register-register ALU operations, OR with an immediate, word load, word store and branch on equal.

An external sequencer drives every enable and select on each cycle. The datapath gives back the opcode, the function field and an operand-equality flag, so that the sequencer can choose its next step. Instruction memory and data memory sit outside the block. The instruction address is the PC, and the data address is the ALU result register. The store data is operand register B. The sequencer drives the data-memory write strobe to the memory itself.

Top module: `mcDatapath`

## Requirements
- R1: While `rstN` is low, the PC is set to `RESET_PC` (default 0), and all holding registers and all register-file entries are set to zero. After reset, `opcode`, `funct`, `dAddr` and `dWrData` read zero and `equal` reads 1.
- R2: On a clock with `irEn` high, the instruction register takes `iData`. `opcode` shows bits 31:26 of that register and `funct` shows bits 5:0. With `irEn` low the register keeps its value.
- R3: On a clock with `abEn` high, operand A takes the register addressed by instruction bits 25:21 and operand B takes the register addressed by bits 20:16. B drives `dWrData`. `equal` is 1 exactly when A equals B.
- R4: The second ALU input is B when `aluSrcB` is 0 or 3. It is the sign-extended instruction bits 15:0 when `aluSrcB` is 1, and the zero-extended bits 15:0 when `aluSrcB` is 2. `aluMode` selects the operation: 0 add, 1 OR, 2 from the function field, 3 subtract. On a clock with `rEn` high, the result register takes the ALU output, and `dAddr` shows that register.
- R5: In function-field mode, the function codes select these operations: 0x20 and 0x21 add, 0x22 and 0x23 subtract, 0x24 AND, 0x25 OR, 0x26 XOR, 0x27 NOR, 0x2A signed set-less-than (result 1 or 0). Any other code adds.
- R6: On a clock with `mEn` high, the memory register takes `dRdData`.
- R7: On a clock with `regWr` high, the register file writes one register. The data is the memory register when `memToReg` is 1, and the result register otherwise. The destination is instruction bits 15:11 when `regDst` is 1, and bits 20:16 otherwise.
- R8: Register 0 always reads as zero. A write to it has no effect.
- R9: On a clock with `pcEn` high and `pcSel` low, the PC advances by 4. With `pcEn` and `pcSel` both high, the PC becomes PC + 4 + (sign-extended bits 15:0 shifted left by 2) when `equal` is 1, and PC + 4 otherwise. With `pcEn` low the PC holds. `iAddr` shows the PC.
- R10: Each holding register loads only when its own enable is high, and keeps its value on every other clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| iAddr | output | 32 | Instruction fetch address (PC) |
| iData | input | 32 | Instruction word read at `iAddr` |
| dAddr | output | 32 | Data memory address (result register) |
| dWrData | output | 32 | Data memory store value (operand B) |
| dRdData | input | 32 | Data memory word read at `dAddr` |
| irEn | input | 1 | Load instruction register |
| abEn | input | 1 | Load operand registers A and B |
| rEn | input | 1 | Load ALU result register |
| mEn | input | 1 | Load memory data register |
| pcEn | input | 1 | Update the PC |
| pcSel | input | 1 | 0: PC + 4; 1: branch if equal |
| regWr | input | 1 | Write the register file |
| regDst | input | 1 | Destination select: 1 rd field, 0 rt field |
| memToReg | input | 1 | Write-back source: 1 memory register, 0 result register |
| aluSrcB | input | 2 | Second ALU operand select |
| aluMode | input | 2 | ALU operation select |
| opcode | output | 6 | Instruction bits 31:26 |
| funct | output | 6 | Instruction bits 5:0 |
| equal | output | 1 | Operand A equals operand B |

## Verification
The assertions assume that `RESET_PC` is word aligned and that the sequencer never moves the PC except through `pcEn`. Under those assumptions, every PC step and branch keeps `iAddr` aligned. The hold checks assume nothing about the enables, so any mix of enables is legal. The bench drives the fetch, operand, execute, memory and write-back steps for each instruction class, and it inserts cycles with every enable low. Its memories are word-indexed by address bits 7:2. The test program keeps its data addresses aligned and inside that range.

// File: rtl/mcDpPkg.sv
package mcDpPkg;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR, ALU_SLT
  } aluOp_e;

  typedef enum logic [1:0] {
    SRCB_REG  = 2'd0,
    SRCB_SEXT = 2'd1,
    SRCB_ZEXT = 2'd2,
    SRCB_ALT  = 2'd3
  } srcB_e;

  // strobes handed from the control decoder to the datapath
  typedef struct packed {
    logic   irEn;
    logic   abEn;
    logic   rEn;
    logic   mEn;
    logic   pcEn;
    logic   pcSel;
    logic   regWr;
    logic   regDst;
    logic   memToReg;
    srcB_e  srcB;
    aluOp_e aluOp;
  } dpStrobe_t;

endpackage

// File: rtl/dpCtrl.sv
module dpCtrl
  import mcDpPkg::*;
(
  input  logic       irEn,
  input  logic       abEn,
  input  logic       rEn,
  input  logic       mEn,
  input  logic       pcEn,
  input  logic       pcSel,
  input  logic       regWr,
  input  logic       regDst,
  input  logic       memToReg,
  input  logic [1:0] aluSrcB,
  input  logic [1:0] aluMode,
  input  logic [5:0] funct,
  output dpStrobe_t  strobe
);

  aluOp_e fnOp;

  always_comb begin
    unique case (funct)
      6'h22, 6'h23: fnOp = ALU_SUB;
      6'h24:        fnOp = ALU_AND;
      6'h25:        fnOp = ALU_OR;
      6'h26:        fnOp = ALU_XOR;
      6'h27:        fnOp = ALU_NOR;
      6'h2A:        fnOp = ALU_SLT;
      default:      fnOp = ALU_ADD;
    endcase
  end

  always_comb begin
    strobe.irEn     = irEn;
    strobe.abEn     = abEn;
    strobe.rEn      = rEn;
    strobe.mEn      = mEn;
    strobe.pcEn     = pcEn;
    strobe.pcSel    = pcSel;
    strobe.regWr    = regWr;
    strobe.regDst   = regDst;
    strobe.memToReg = memToReg;
    strobe.srcB     = srcB_e'(aluSrcB);
    unique case (aluMode)
      2'd0:    strobe.aluOp = ALU_ADD;
      2'd1:    strobe.aluOp = ALU_OR;
      2'd2:    strobe.aluOp = fnOp;
      default: strobe.aluOp = ALU_SUB;
    endcase
  end

endmodule

// File: rtl/dpRegFile.sv
module dpRegFile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int RA_W = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [RA_W-1:0] rdAddrA,
  input  logic [RA_W-1:0] rdAddrB,
  input  logic            wrEn,
  input  logic [RA_W-1:0] wrAddr,
  input  logic [XLEN-1:0] wrData,
  output logic [XLEN-1:0] rdDataA,
  output logic [XLEN-1:0] rdDataB
);

  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wrEn && wrAddr != '0) begin
      regs[wrAddr] <= wrData;
    end
  end

  assign rdDataA = (rdAddrA == '0) ? '0 : regs[rdAddrA];
  assign rdDataB = (rdAddrB == '0) ? '0 : regs[rdAddrB];

endmodule

// File: rtl/dpAlu.sv
module dpAlu
  import mcDpPkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  input  aluOp_e          op,
  output logic [XLEN-1:0] res
);

  always_comb begin
    unique case (op)
      ALU_SUB: res = opA - opB;
      ALU_AND: res = opA & opB;
      ALU_OR:  res = opA | opB;
      ALU_XOR: res = opA ^ opB;
      ALU_NOR: res = ~(opA | opB);
      ALU_SLT: res = {{(XLEN-1){1'b0}}, ($signed(opA) < $signed(opB))};
      default: res = opA + opB;
    endcase
  end

endmodule

// File: rtl/dpPath.sv
module dpPath
  import mcDpPkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          NREG     = 32,
  parameter logic [31:0] RESET_PC = 32'h0,
  localparam int         RA_W     = $clog2(NREG),
  localparam int         IMM_W    = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  dpStrobe_t       strobe,
  input  logic [XLEN-1:0] iData,
  input  logic [XLEN-1:0] dRdData,
  output logic [XLEN-1:0] iAddr,
  output logic [XLEN-1:0] dAddr,
  output logic [XLEN-1:0] dWrData,
  output logic [5:0]      opcode,
  output logic [5:0]      funct,
  output logic            equal
);

  logic [XLEN-1:0] pc, ir, aReg, bReg, rReg, mReg;
  logic [XLEN-1:0] rfA, rfB, wbData, aluB, aluY;
  logic [XLEN-1:0] sExt, zExt, pcInc, brTarget;
  logic [RA_W-1:0] wbAddr;

  assign sExt     = {{(XLEN-IMM_W){ir[IMM_W-1]}}, ir[IMM_W-1:0]};
  assign zExt     = {{(XLEN-IMM_W){1'b0}}, ir[IMM_W-1:0]};
  assign pcInc    = pc + XLEN'(4);
  assign brTarget = pcInc + (sExt << 2);
  assign wbData   = strobe.memToReg ? mReg : rReg;
  assign wbAddr   = strobe.regDst ? ir[11 +: RA_W] : ir[16 +: RA_W];

  always_comb begin
    unique case (strobe.srcB)
      SRCB_SEXT: aluB = sExt;
      SRCB_ZEXT: aluB = zExt;
      default:   aluB = bReg;
    endcase
  end

  dpRegFile #(.XLEN(XLEN), .NREG(NREG)) uRegFile (
    .clk     (clk),
    .rstN    (rstN),
    .rdAddrA (ir[21 +: RA_W]),
    .rdAddrB (ir[16 +: RA_W]),
    .wrEn    (strobe.regWr),
    .wrAddr  (wbAddr),
    .wrData  (wbData),
    .rdDataA (rfA),
    .rdDataB (rfB)
  );

  dpAlu #(.XLEN(XLEN)) uAlu (
    .opA (aReg),
    .opB (aluB),
    .op  (strobe.aluOp),
    .res (aluY)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc   <= XLEN'(RESET_PC);
      ir   <= '0;
      aReg <= '0;
      bReg <= '0;
      rReg <= '0;
      mReg <= '0;
    end else begin
      if (strobe.irEn) ir <= iData;
      if (strobe.abEn) begin
        aReg <= rfA;
        bReg <= rfB;
      end
      if (strobe.rEn) rReg <= aluY;
      if (strobe.mEn) mReg <= dRdData;
      if (strobe.pcEn) pc <= (strobe.pcSel && equal) ? brTarget : pcInc;
    end
  end

  assign iAddr   = pc;
  assign dAddr   = rReg;
  assign dWrData = bReg;
  assign opcode  = ir[31:26];
  assign funct   = ir[5:0];
  assign equal   = (aReg == bReg);

endmodule

// File: rtl/mcDatapath.sv
module mcDatapath
  import mcDpPkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          NREG     = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic            clk,
  input  logic            rstN,
  output logic [XLEN-1:0] iAddr,
  input  logic [XLEN-1:0] iData,
  output logic [XLEN-1:0] dAddr,
  output logic [XLEN-1:0] dWrData,
  input  logic [XLEN-1:0] dRdData,
  input  logic            irEn,
  input  logic            abEn,
  input  logic            rEn,
  input  logic            mEn,
  input  logic            pcEn,
  input  logic            pcSel,
  input  logic            regWr,
  input  logic            regDst,
  input  logic            memToReg,
  input  logic [1:0]      aluSrcB,
  input  logic [1:0]      aluMode,
  output logic [5:0]      opcode,
  output logic [5:0]      funct,
  output logic            equal
);

  dpStrobe_t strobe;

  dpCtrl uCtrl (
    .irEn     (irEn),
    .abEn     (abEn),
    .rEn      (rEn),
    .mEn      (mEn),
    .pcEn     (pcEn),
    .pcSel    (pcSel),
    .regWr    (regWr),
    .regDst   (regDst),
    .memToReg (memToReg),
    .aluSrcB  (aluSrcB),
    .aluMode  (aluMode),
    .funct    (funct),
    .strobe   (strobe)
  );

  dpPath #(.XLEN(XLEN), .NREG(NREG), .RESET_PC(RESET_PC)) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .iData   (iData),
    .dRdData (dRdData),
    .iAddr   (iAddr),
    .dAddr   (dAddr),
    .dWrData (dWrData),
    .opcode  (opcode),
    .funct   (funct),
    .equal   (equal)
  );

endmodule

// File: rtl/mcDatapathChk.sv
module mcDatapathChk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            irEn,
  input logic            abEn,
  input logic            rEn,
  input logic            pcEn,
  input logic            pcSel,
  input logic [XLEN-1:0] iAddr,
  input logic [XLEN-1:0] iData,
  input logic [XLEN-1:0] dAddr,
  input logic [XLEN-1:0] dWrData,
  input logic [5:0]      opcode,
  input logic [5:0]      funct
);

  a_r2_ir_load: assert property (@(posedge clk) disable iff (!rstN)
    irEn |=> (opcode == $past(iData[31:26])) && (funct == $past(iData[5:0])));

  a_r2_ir_hold: assert property (@(posedge clk) disable iff (!rstN)
    !irEn |=> $stable(opcode) && $stable(funct));

  a_r9_pc_hold: assert property (@(posedge clk) disable iff (!rstN)
    !pcEn |=> $stable(iAddr));

  a_r9_pc_step: assert property (@(posedge clk) disable iff (!rstN)
    (pcEn && !pcSel) |=> iAddr == $past(iAddr) + XLEN'(4));

  a_r9_pc_align: assert property (@(posedge clk) disable iff (!rstN)
    iAddr[1:0] == 2'b00);

  a_r10_r_hold: assert property (@(posedge clk) disable iff (!rstN)
    !rEn |=> $stable(dAddr));

  a_r10_b_hold: assert property (@(posedge clk) disable iff (!rstN)
    !abEn |=> $stable(dWrData));

endmodule

bind mcDatapath mcDatapathChk #(.XLEN(XLEN)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .irEn    (irEn),
  .abEn    (abEn),
  .rEn     (rEn),
  .pcEn    (pcEn),
  .pcSel   (pcSel),
  .iAddr   (iAddr),
  .iData   (iData),
  .dAddr   (dAddr),
  .dWrData (dWrData),
  .opcode  (opcode),
  .funct   (funct)
);

// File: tb/tb_mcDatapath.sv
`timescale 1ns/1ps
module tb_mcDatapath;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN;
  logic [31:0] iAddr, iData, dAddr, dWrData, dRdData;
  logic        irEn, abEn, rEn, mEn, pcEn, pcSel, regWr, regDst, memToReg, memWr;
  logic [1:0]  aluSrcB, aluMode;
  logic [5:0]  opcode, funct;
  logic        equal;

  mcDatapath dut (
    .clk(clk), .rstN(rstN), .iAddr(iAddr), .iData(iData), .dAddr(dAddr),
    .dWrData(dWrData), .dRdData(dRdData), .irEn(irEn), .abEn(abEn), .rEn(rEn),
    .mEn(mEn), .pcEn(pcEn), .pcSel(pcSel), .regWr(regWr), .regDst(regDst),
    .memToReg(memToReg), .aluSrcB(aluSrcB), .aluMode(aluMode),
    .opcode(opcode), .funct(funct), .equal(equal)
  );

  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  logic [31:0] refDmem [64];

  assign iData   = imem[iAddr[7:2]];
  assign dRdData = dmem[dAddr[7:2]];

  always @(posedge clk) if (rstN && memWr) dmem[dAddr[7:2]] <= dWrData;

  int    nChecks = 0;
  int    nBad    = 0;
  bit    cmpOn   = 0;
  bit    allDone = 0;
  string curTag  = "R4";

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  logic [31:0] mPc, mIr, mA, mB, mR, mM;
  logic [31:0] mRegs [32];

  function automatic logic [31:0] refAlu(logic [1:0] mode, logic [5:0] fn,
                                         logic [31:0] x, logic [31:0] y);
    int sel;
    if (mode == 2'd0) sel = 0;
    else if (mode == 2'd1) sel = 3;
    else if (mode == 2'd3) sel = 1;
    else begin
      case (fn)
        6'h22, 6'h23: sel = 1;
        6'h24: sel = 2;
        6'h25: sel = 3;
        6'h26: sel = 4;
        6'h27: sel = 5;
        6'h2A: sel = 6;
        default: sel = 0;
      endcase
    end
    case (sel)
      1: return x - y;
      2: return x & y;
      3: return x | y;
      4: return x ^ y;
      5: return ~(x | y);
      6: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      default: return x + y;
    endcase
  endfunction

  always @(posedge clk) begin : refModel
    logic [31:0] sx, zx, opB, nPc, rsV, rtV;
    logic [4:0]  dst;
    if (!rstN) begin
      mPc = 0; mIr = 0; mA = 0; mB = 0; mR = 0; mM = 0;
      for (int i = 0; i < 32; i++) mRegs[i] = 0;
    end else begin
      sx  = {{16{mIr[15]}}, mIr[15:0]};
      zx  = {16'h0, mIr[15:0]};
      opB = (aluSrcB == 2'd1) ? sx : (aluSrcB == 2'd2) ? zx : mB;
      rsV = mRegs[mIr[25:21]];
      rtV = mRegs[mIr[20:16]];
      nPc = mPc;
      if (pcEn) nPc = (pcSel && mA == mB) ? mPc + 4 + (sx << 2) : mPc + 4;
      if (memWr) refDmem[mR[7:2]] = mB;
      if (rEn) mR = refAlu(aluMode, mIr[5:0], mA, opB);
      if (regWr) begin
        dst = regDst ? mIr[15:11] : mIr[20:16];
        if (dst != 0) mRegs[dst] = memToReg ? mM : mR;
      end
      if (mEn) mM = refDmem[mR[7:2]];
      if (abEn) begin mA = rsV; mB = rtV; end
      if (irEn) mIr = imem[mPc[7:2]];
      mPc = nPc;
    end
  end

  // compare each cycle, away from the rising edge
  always @(negedge clk) begin
    if (cmpOn) begin
      check("R9", "iAddr", iAddr, mPc);
      check("R2", "opcode", {26'h0, opcode}, {26'h0, mIr[31:26]});
      check("R2", "funct", {26'h0, funct}, {26'h0, mIr[5:0]});
      check("R3", "equal", {31'h0, equal}, {31'h0, (mA == mB)});
      check("R3", "dWrData", dWrData, mB);
      check(curTag, "dAddr", dAddr, mR);
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [31:0] encR(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] encI(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic idleCtl();
    irEn = 0; abEn = 0; rEn = 0; mEn = 0; pcEn = 0; pcSel = 0;
    regWr = 0; regDst = 0; memToReg = 0; memWr = 0; aluSrcB = 0; aluMode = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    idleCtl();
  endtask

  task automatic runInstr(bit addIdle);
    irEn = 1; tick();
    abEn = 1; tick();
    if (addIdle) begin
      curTag = "R10"; tick();
    end
    case (mIr[31:26])
      6'h00: begin
        curTag = "R5";
        aluSrcB = 0; aluMode = 2; rEn = 1; tick();
        regWr = 1; regDst = 1; pcEn = 1; tick();
      end
      6'h0D: begin
        curTag = (mIr[20:16] == 0) ? "R8" : "R4";
        aluSrcB = 2; aluMode = 1; rEn = 1; tick();
        regWr = 1; pcEn = 1; tick();
      end
      6'h23: begin
        curTag = "R6";
        aluSrcB = 1; rEn = 1; tick();
        mEn = 1; tick();
        regWr = 1; memToReg = 1; pcEn = 1; tick();
      end
      6'h2B: begin
        curTag = "R4";
        aluSrcB = 1; rEn = 1; tick();
        memWr = 1; pcEn = 1; tick();
      end
      default: begin
        curTag = "R9";
        pcEn = 1; pcSel = 1; tick();
      end
    endcase
    curTag = "R4";
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    if (!allDone) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  initial begin : mainSeq
    for (int i = 0; i < 64; i++) begin
      imem[i] = encR(0, 0, 0, 6'h20);
      dmem[i] = 0;
      refDmem[i] = 0;
    end
    dmem[5] = 32'hDEADBEEF; refDmem[5] = 32'hDEADBEEF;
    imem[0]  = encI(6'h0D, 0, 1, 16'h00F0);
    imem[1]  = encI(6'h0D, 0, 2, 16'hFFFF);
    imem[2]  = encR(1, 2, 3, 6'h20);
    imem[3]  = encR(1, 2, 4, 6'h22);
    imem[4]  = encR(2, 1, 5, 6'h24);
    imem[5]  = encR(1, 2, 6, 6'h25);
    imem[6]  = encR(1, 2, 7, 6'h26);
    imem[7]  = encR(1, 2, 8, 6'h27);
    imem[8]  = encR(4, 1, 9, 6'h2A);
    imem[9]  = encI(6'h0D, 0, 0, 16'h1234);
    imem[10] = encI(6'h2B, 0, 3, 16'd8);
    imem[11] = encI(6'h2B, 0, 9, 16'd16);
    imem[12] = encI(6'h23, 0, 10, 16'd8);
    imem[13] = encR(10, 0, 11, 6'h20);
    imem[14] = encI(6'h04, 1, 1, 16'd2);
    imem[15] = encI(6'h0D, 0, 12, 16'd1);
    imem[16] = encI(6'h0D, 0, 12, 16'd2);
    imem[17] = encI(6'h04, 1, 2, 16'd5);
    imem[18] = encI(6'h2B, 0, 11, 16'd12);
    imem[19] = encI(6'h2B, 0, 0, 16'd20);
    imem[20] = encR(1, 2, 13, 6'h3F);
    imem[21] = encI(6'h04, 0, 0, -16'sd22);

    idleCtl();
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: state after reset
    check("R1", "iAddr", iAddr, 32'h0);
    check("R1", "opcode", {26'h0, opcode}, 32'h0);
    check("R1", "funct", {26'h0, funct}, 32'h0);
    check("R1", "dAddr", dAddr, 32'h0);
    check("R1", "dWrData", dWrData, 32'h0);
    check("R1", "equal", {31'h0, equal}, 32'h1);
    cmpOn = 1;

    for (int n = 0; n < 30; n++) runInstr((n % 3) == 1);

    // R10: all enables low for a stretch
    curTag = "R10";
    repeat (4) tick();
    curTag = "R4";
    cmpOn = 0;

    check("R5", "add result stored", dmem[2], 32'h000100EF);
    check("R5", "signed slt stored", dmem[4], 32'h1);
    check("R6", "loaded then stored", dmem[3], 32'h000100EF);
    check("R8", "r0 stored as zero", dmem[5], 32'h0);
    for (int i = 0; i < 8; i++) check("R7", "data memory word", dmem[i], refDmem[i]);

    allDone = 1;
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule